// File: doc/BRIEF.md
# Command Ring Stream Decoder

This block empties a ring of 64-bit command descriptors that a producer fills. The producer moves a put index forward. The block reads descriptors at its own get index. Each descriptor packs a byte address and a byte length for a buffer of 32-bit command words. The block fetches those words one at a time over a simple word-read memory port. It splits the stream into method headers and data words. As it walks each data word, it steps the method byte address by 4. Every (method, data) pair then goes to one of three places:

- a state-register write port, when the method falls inside the mapped register window;
- a special-command dispatch port, when it falls inside the special window;
- nowhere, when it falls inside neither window.

A dispatched special command completes with either a plain acknowledge or an acknowledge plus a yield request. On a yield, the block rewinds to the header word of that command and leaves the get index unchanged. It then starts the same command again from its header. Each yield also reports whether the block made any forward progress in the current buffer since the current attempt began. A header whose kind field is not allowed stops all fetching for good, until the next reset.

Top module: `cmdstream_decoder`

## Requirements
- R1: After reset, get_idx is 0. busy, err, st_we, disp_req, yield_evt and idle_pulse are all 0.
- R2: A descriptor is read as two words: the low word at ring_base + 8*slot, then the high word at +4. The buffer byte address is descriptor bits [37:2] shifted left by 2. The buffer length in words is descriptor bits [62:42]. Bits [41:38] and bit 63 are ignored.
- R3: A header word is decoded as follows. Bits [30:28] give the kind, [27:16] the data-word count, [15:13] the subchannel and [12:0] the method dword index. The method byte address is the index shifted left by 2. Exactly "count" data words follow the header. The method address rises by 4 after each data word. A count of 0 consumes only the header.
- R4: For a method byte address m with STATE_BASE <= m < STATE_BASE + 4*STATE_REGS, the data word is written through the state port at index (m - STATE_BASE)/4. A method in neither window produces no write and no dispatch.
- R5: For a method byte address m with SPEC_BASE <= m < SPEC_BASE + 4*SPEC_CNT, the block raises disp_req with the method address, the subchannel and the data word. It holds all of them stable until disp_ack, and fetches nothing while it waits.
- R6: If disp_ack comes with disp_yield, the block does not move get_idx. It fetches the same header word again and replays every data word of that command, including words that were already dispatched.
- R7: Each yield raises yield_evt for one cycle. At the same time, yield_progress is 1 if the yielding header lies after the point where the current attempt began. An attempt begins at the start of a buffer and again after each yield.
- R8: get_idx advances by one, wrapping from RING_DEPTH-1 to 0. This happens only after every word of the current buffer has been consumed. A buffer of length 0 is skipped and get_idx still advances.
- R9: busy is high while get_idx differs from put_idx or a buffer is in progress. When busy falls without an error, idle_pulse is high for exactly one cycle.
- R10: A header whose kind bit is clear in KIND_MASK sets err. With the default mask, only kinds 1 and 6 are allowed. err stays set until reset. While err is set, no memory read is issued, get_idx is frozen, no state write happens and busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_base | input | AW | Byte address of ring slot 0 |
| put_idx | input | IDX_W | Producer put index |
| get_idx | output | IDX_W | Consumer get index |
| mem_req | output | 1 | Word read request, one cycle per read |
| mem_addr | output | AW | Byte address of the word to read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| st_we | output | 1 | State register write strobe |
| st_idx | output | SIDX_W | State register index |
| st_data | output | 32 | State register write data |
| disp_req | output | 1 | Special command request |
| disp_mthd | output | 15 | Special command method byte address |
| disp_subch | output | 3 | Special command subchannel |
| disp_data | output | 32 | Special command data word |
| disp_ack | input | 1 | Special command completion |
| disp_yield | input | 1 | With disp_ack: rewind and retry |
| yield_evt | output | 1 | One-cycle pulse per yield |
| yield_progress | output | 1 | Forward progress flag valid with yield_evt |
| busy | output | 1 | Work pending or in progress |
| idle_pulse | output | 1 | One-cycle pulse when the ring drains |
| err | output | 1 | Sticky unsupported header kind flag |

## Verification
The hardest case to reach is a yield in the middle of a multi-word special command. The stimulus has to place it late in a buffer that has already finished other commands. It must then be followed by a second yield on the same command, so that the progress flag goes from 1 to 0 and both dispatched words are replayed. The bench builds exactly this: a buffer whose fourth command is a two-word dispatch. A scripted responder yields on the second word twice and accepts it on the third try. The scoreboard expects the full replay order. A later buffer yields on its very first command, which checks that progress is 0 at the start of a buffer. Ring wrap-around comes from reusing slot 0 after three slots have been consumed.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;

  localparam int MADDR_W = 15;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ENT_LO,
    ST_ENT_HI,
    ST_HDR,
    ST_DAT,
    ST_DISP,
    ST_ADV,
    ST_HALT
  } dec_state_e;

  typedef struct packed {
    logic [2:0]  kind;
    logic [11:0] count;
    logic [2:0]  subch;
    logic [12:0] mindex;
  } mhdr_t;

endpackage

// File: rtl/cmd_hdr_decode.sv
module cmd_hdr_decode
  import cmdq_pkg::*;
#(
  parameter logic [7:0] KIND_MASK = 8'b0100_0010
) (
  input  logic [31:0]        word,
  output mhdr_t              hdr,
  output logic [MADDR_W-1:0] maddr,
  output logic               supported
);

  always_comb begin
    hdr.kind   = word[30:28];
    hdr.count  = word[27:16];
    hdr.subch  = word[15:13];
    hdr.mindex = word[12:0];
    maddr      = {hdr.mindex, 2'b00};
    supported  = KIND_MASK[hdr.kind];
  end

endmodule

// File: rtl/cmd_method_route.sv
module cmd_method_route
  import cmdq_pkg::*;
#(
  parameter int STATE_REGS = 16,
  parameter int STATE_BASE = 'h200,
  parameter int SPEC_CNT   = 4,
  parameter int SPEC_BASE  = 'h100,
  localparam int SIDX_W    = $clog2(STATE_REGS)
) (
  input  logic [MADDR_W-1:0] maddr,
  output logic               is_state,
  output logic [SIDX_W-1:0]  state_idx,
  output logic               is_spec
);

  localparam logic [MADDR_W-1:0] ST_BASE_W = MADDR_W'(STATE_BASE);
  localparam logic [MADDR_W:0]   ST_SPAN   = (MADDR_W+1)'(STATE_REGS * 4);

  logic [MADDR_W-1:0] st_off;

  always_comb begin
    st_off    = maddr - ST_BASE_W;
    is_state  = (maddr >= ST_BASE_W) && ({1'b0, st_off} < ST_SPAN);
    state_idx = st_off[SIDX_W+1:2];
  end

  generate
    if (SPEC_CNT > 0) begin : g_spec
      localparam logic [MADDR_W-1:0] SP_BASE_W = MADDR_W'(SPEC_BASE);
      localparam logic [MADDR_W:0]   SP_SPAN   = (MADDR_W+1)'(SPEC_CNT * 4);
      logic [MADDR_W-1:0] sp_off;
      always_comb begin
        sp_off  = maddr - SP_BASE_W;
        is_spec = (maddr >= SP_BASE_W) && ({1'b0, sp_off} < SP_SPAN);
      end
    end else begin : g_nospec
      assign is_spec = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/cmd_ring_ctrl.sv
module cmd_ring_ctrl #(
  parameter int RING_DEPTH = 4,
  localparam int IDX_W     = $clog2(RING_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  input  logic [IDX_W-1:0] put_idx,
  output logic [IDX_W-1:0] get_idx,
  output logic             pending
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(RING_DEPTH - 1);

  logic [IDX_W-1:0] get_d;

  always_comb begin
    get_d   = (get_idx == LAST) ? '0 : get_idx + 1'b1;
    pending = (get_idx != put_idx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       get_idx <= '0;
    else if (advance) get_idx <= get_d;
  end

endmodule

// File: rtl/cmdstream_decoder.sv
module cmdstream_decoder
  import cmdq_pkg::*;
#(
  parameter int RING_DEPTH          = 4,
  parameter int AW                  = 38,
  parameter int STATE_REGS          = 16,
  parameter int STATE_BASE          = 'h200,
  parameter int SPEC_CNT            = 4,
  parameter int SPEC_BASE           = 'h100,
  parameter logic [7:0] KIND_MASK   = 8'b0100_0010,
  localparam int IDX_W              = $clog2(RING_DEPTH),
  localparam int SIDX_W             = $clog2(STATE_REGS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      ring_base,
  input  logic [IDX_W-1:0]   put_idx,
  output logic [IDX_W-1:0]   get_idx,
  output logic               mem_req,
  output logic [AW-1:0]      mem_addr,
  input  logic               mem_rvalid,
  input  logic [31:0]        mem_rdata,
  output logic               st_we,
  output logic [SIDX_W-1:0]  st_idx,
  output logic [31:0]        st_data,
  output logic               disp_req,
  output logic [14:0]        disp_mthd,
  output logic [2:0]         disp_subch,
  output logic [31:0]        disp_data,
  input  logic               disp_ack,
  input  logic               disp_yield,
  output logic               yield_evt,
  output logic               yield_progress,
  output logic               busy,
  output logic               idle_pulse,
  output logic               err
);

  localparam int PW = 21;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_s1, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_i  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_i  <= rst_s1;
    end
  end

  dec_state_e         state_q, state_d;
  logic [31:0]        lo_q, lo_d;
  logic [AW-1:0]      bufa_q, bufa_d;
  logic [PW-1:0]      nwords_q, nwords_d;
  logic [PW-1:0]      ptr_q, ptr_d;
  logic [PW-1:0]      hptr_q, hptr_d;
  logic [PW-1:0]      aptr_q, aptr_d;
  logic [MADDR_W-1:0] maddr_q, maddr_d;
  logic [11:0]        rem_q, rem_d;
  logic [2:0]         subch_q, subch_d;
  logic [31:0]        data_q, data_d;
  logic               pend_q, pend_d;
  logic               we_q, we_d;
  logic [SIDX_W-1:0]  widx_q, widx_d;
  logic [31:0]        wdat_q, wdat_d;
  logic               yev_q, yev_d;
  logic               yprog_q, yprog_d;
  logic               err_q, err_d;
  logic               busy_q;
  logic               advance, pending, rd_done;

  mhdr_t              hdr;
  logic [MADDR_W-1:0] hdr_maddr;
  logic               hdr_ok;
  logic               is_state, is_spec;
  logic [SIDX_W-1:0]  sidx;

  cmd_ring_ctrl #(.RING_DEPTH(RING_DEPTH)) i_ring (
    .clk     (clk),
    .rst_n   (rst_i),
    .advance (advance),
    .put_idx (put_idx),
    .get_idx (get_idx),
    .pending (pending)
  );

  cmd_hdr_decode #(.KIND_MASK(KIND_MASK)) i_hdr (
    .word      (mem_rdata),
    .hdr       (hdr),
    .maddr     (hdr_maddr),
    .supported (hdr_ok)
  );

  cmd_method_route #(
    .STATE_REGS (STATE_REGS),
    .STATE_BASE (STATE_BASE),
    .SPEC_CNT   (SPEC_CNT),
    .SPEC_BASE  (SPEC_BASE)
  ) i_route (
    .maddr     (maddr_q),
    .is_state  (is_state),
    .state_idx (sidx),
    .is_spec   (is_spec)
  );

  function automatic dec_state_e after_cmd(input logic [PW-1:0] p, input logic [PW-1:0] n);
    return (p >= n) ? ST_ADV : ST_HDR;
  endfunction

  // memory port
  always_comb begin
    mem_req  = 1'b0;
    mem_addr = '0;
    unique case (state_q)
      ST_ENT_LO: begin
        mem_req  = !pend_q;
        mem_addr = ring_base + AW'({get_idx, 3'b000});
      end
      ST_ENT_HI: begin
        mem_req  = !pend_q;
        mem_addr = ring_base + AW'({get_idx, 3'b100});
      end
      ST_HDR, ST_DAT: begin
        mem_req  = !pend_q;
        mem_addr = bufa_q + AW'({ptr_q, 2'b00});
      end
      default: ;
    endcase
  end

  assign rd_done = pend_q && mem_rvalid;

  // next-state logic
  always_comb begin
    state_d  = state_q;
    lo_d     = lo_q;
    bufa_d   = bufa_q;
    nwords_d = nwords_q;
    ptr_d    = ptr_q;
    hptr_d   = hptr_q;
    aptr_d   = aptr_q;
    maddr_d  = maddr_q;
    rem_d    = rem_q;
    subch_d  = subch_q;
    data_d   = data_q;
    pend_d   = pend_q;
    we_d     = 1'b0;
    widx_d   = widx_q;
    wdat_d   = wdat_q;
    yev_d    = 1'b0;
    yprog_d  = yprog_q;
    err_d    = err_q;
    advance  = 1'b0;

    if (mem_req)      pend_d = 1'b1;
    else if (rd_done) pend_d = 1'b0;

    unique case (state_q)
      ST_IDLE: if (pending) state_d = ST_ENT_LO;
      ST_ENT_LO: if (rd_done) begin
        lo_d    = mem_rdata;
        state_d = ST_ENT_HI;
      end
      ST_ENT_HI: if (rd_done) begin
        bufa_d   = AW'({mem_rdata[5:0], lo_q[31:2], 2'b00});
        nwords_d = mem_rdata[30:10];
        ptr_d    = '0;
        aptr_d   = '0;
        state_d  = (mem_rdata[30:10] == '0) ? ST_ADV : ST_HDR;
      end
      ST_HDR: if (rd_done) begin
        hptr_d  = ptr_q;
        ptr_d   = ptr_q + 1'b1;
        maddr_d = hdr_maddr;
        rem_d   = hdr.count;
        subch_d = hdr.subch;
        if (!hdr_ok) begin
          err_d   = 1'b1;
          state_d = ST_HALT;
        end else if (hdr.count == '0) begin
          state_d = after_cmd(ptr_q + 1'b1, nwords_q);
        end else begin
          state_d = ST_DAT;
        end
      end
      ST_DAT: if (rd_done) begin
        ptr_d  = ptr_q + 1'b1;
        data_d = mem_rdata;
        if (is_spec) begin
          state_d = ST_DISP;
        end else begin
          we_d    = is_state;
          widx_d  = sidx;
          wdat_d  = mem_rdata;
          maddr_d = maddr_q + MADDR_W'(4);
          rem_d   = rem_q - 1'b1;
          state_d = (rem_q == 12'd1) ? after_cmd(ptr_q + 1'b1, nwords_q) : ST_DAT;
        end
      end
      ST_DISP: if (disp_ack) begin
        if (disp_yield) begin
          ptr_d   = hptr_q;
          aptr_d  = hptr_q;
          yev_d   = 1'b1;
          yprog_d = (hptr_q != aptr_q);
          state_d = ST_HDR;
        end else begin
          maddr_d = maddr_q + MADDR_W'(4);
          rem_d   = rem_q - 1'b1;
          state_d = (rem_q == 12'd1) ? after_cmd(ptr_q, nwords_q) : ST_DAT;
        end
      end
      ST_ADV: begin
        advance = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_HALT;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
      we_q    <= 1'b0;
      yev_q   <= 1'b0;
      yprog_q <= 1'b0;
      err_q   <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      we_q    <= we_d;
      yev_q   <= yev_d;
      yprog_q <= yprog_d;
      err_q   <= err_d;
      busy_q  <= busy;
    end
  end

  // datapath registers
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      lo_q     <= '0;
      bufa_q   <= '0;
      nwords_q <= '0;
      ptr_q    <= '0;
      hptr_q   <= '0;
      aptr_q   <= '0;
      maddr_q  <= '0;
      rem_q    <= '0;
      subch_q  <= '0;
      data_q   <= '0;
      widx_q   <= '0;
      wdat_q   <= '0;
    end else begin
      lo_q     <= lo_d;
      bufa_q   <= bufa_d;
      nwords_q <= nwords_d;
      ptr_q    <= ptr_d;
      hptr_q   <= hptr_d;
      aptr_q   <= aptr_d;
      maddr_q  <= maddr_d;
      rem_q    <= rem_d;
      subch_q  <= subch_d;
      data_q   <= data_d;
      widx_q   <= widx_d;
      wdat_q   <= wdat_d;
    end
  end

  always_comb begin
    st_we          = we_q;
    st_idx         = widx_q;
    st_data        = wdat_q;
    disp_req       = (state_q == ST_DISP);
    disp_mthd      = maddr_q;
    disp_subch     = subch_q;
    disp_data      = data_q;
    yield_evt      = yev_q;
    yield_progress = yprog_q;
    err            = err_q;
    busy           = !err_q && (pending || (state_q != ST_IDLE));
    idle_pulse     = busy_q && !busy && !err_q;
  end

endmodule

// File: rtl/cmdstream_decoder_chk.sv
module cmdstream_decoder_chk #(
  parameter int RING_DEPTH = 4,
  parameter int IDX_W      = 2,
  parameter int SIDX_W     = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [IDX_W-1:0] get_idx,
  input logic             mem_req,
  input logic             st_we,
  input logic             disp_req,
  input logic [14:0]      disp_mthd,
  input logic [31:0]      disp_data,
  input logic             disp_ack,
  input logic             disp_yield,
  input logic             yield_evt,
  input logic             busy,
  input logic             idle_pulse,
  input logic             err
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(RING_DEPTH - 1);

  // R8
  get_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (get_idx != $past(get_idx)) |->
      (get_idx == (($past(get_idx) == LAST) ? '0 : $past(get_idx) + 1'b1)));

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  // R10
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!mem_req && !st_we && !busy));

  // R5
  disp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_req && !disp_ack) |=> (disp_req && $stable(disp_mthd) && $stable(disp_data)));

  // R5
  disp_nofetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_req |-> !mem_req);

  // R7
  yield_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    yield_evt |-> $past(disp_req && disp_ack && disp_yield));

  // R6
  yield_get_chk: assert property (@(posedge clk) disable iff (!rst_n)
    yield_evt |-> $stable(get_idx));

  // R9
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_pulse |-> (!busy && $past(busy)));

endmodule

bind cmdstream_decoder cmdstream_decoder_chk #(
  .RING_DEPTH (RING_DEPTH),
  .IDX_W      (IDX_W),
  .SIDX_W     (SIDX_W)
) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .get_idx    (get_idx),
  .mem_req    (mem_req),
  .st_we      (st_we),
  .disp_req   (disp_req),
  .disp_mthd  (disp_mthd),
  .disp_data  (disp_data),
  .disp_ack   (disp_ack),
  .disp_yield (disp_yield),
  .yield_evt  (yield_evt),
  .busy       (busy),
  .idle_pulse (idle_pulse),
  .err        (err)
);

// File: tb/test_cmdstream_decoder.sv
module test_cmdstream_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [37:0] ring_base = '0;
  logic [1:0]  put_idx = '0;
  logic [1:0]  get_idx;
  logic        mem_req;
  logic [37:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        st_we;
  logic [3:0]  st_idx;
  logic [31:0] st_data;
  logic        disp_req;
  logic [14:0] disp_mthd;
  logic [2:0]  disp_subch;
  logic [31:0] disp_data;
  logic        disp_ack = 1'b0;
  logic        disp_yield = 1'b0;
  logic        yield_evt, yield_progress, busy, idle_pulse, err;

  always #5 clk = ~clk;

  cmdstream_decoder i_cmdstream_decoder (
    .clk, .rst_n, .ring_base, .put_idx, .get_idx, .mem_req, .mem_addr,
    .mem_rvalid, .mem_rdata, .st_we, .st_idx, .st_data, .disp_req,
    .disp_mthd, .disp_subch, .disp_data, .disp_ack, .disp_yield,
    .yield_evt, .yield_progress, .busy, .idle_pulse, .err
  );

  logic [31:0] mem [0:1023];
  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (mem_req) begin
      mem_rvalid <= 1'b1;
      mem_rdata  <= mem[mem_addr[11:2]];
    end
  end

  int n_chk = 0, n_err = 0, idle_cnt = 0;
  logic [3:0]  q_widx[$];
  logic [31:0] q_wdat[$];
  logic [14:0] q_dm[$];
  logic [31:0] q_dd[$];
  logic        q_dy[$];
  logic        q_yp[$];
  logic [1:0]  q_yg[$];

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] hw(input int kind, input int cnt, input int sub, input int maddr);
    return {1'b0, 3'(kind), 12'(cnt), 3'(sub), 13'(maddr >> 2)};
  endfunction

  // descriptor: slot, buffer word index, word count; junk in ignored bits
  task automatic put_entry(input int slot, input int bufw, input int nw);
    logic [37:0] ba;
    ba = 38'(bufw * 4);
    mem[2*slot]   = ba[31:0];
    mem[2*slot+1] = {1'b1, 21'(nw), 4'hF, ba[37:32]};
  endtask

  task automatic exp_w(input int idx, input logic [31:0] d);
    q_widx.push_back(4'(idx));
    q_wdat.push_back(d);
  endtask

  task automatic exp_d(input int m, input logic [31:0] d, input logic y);
    q_dm.push_back(15'(m));
    q_dd.push_back(d);
    q_dy.push_back(y);
  endtask

  // scoreboard monitor and dispatch responder
  always @(negedge clk) begin
    if (rst_n) begin
      if (idle_pulse) idle_cnt++;
      if (st_we) begin
        if (q_widx.size() == 0) chk("R4 unexpected write", {st_idx, st_data}, 64'hdead);
        else begin
          chk("R4 write idx", st_idx, q_widx.pop_front());
          chk("R3 write data", st_data, q_wdat.pop_front());
        end
      end
      if (yield_evt) begin
        if (q_yp.size() == 0) chk("R7 unexpected yield", 1, 0);
        else begin
          chk("R7 progress", yield_progress, q_yp.pop_front());
          chk("R6 get held", get_idx, q_yg.pop_front());
        end
      end
      if (disp_ack) begin
        disp_ack   = 1'b0;
        disp_yield = 1'b0;
      end else if (disp_req) begin
        if (q_dm.size() == 0) begin
          chk("R5 unexpected dispatch", disp_mthd, 15'h7fff);
          disp_ack = 1'b1;
        end else begin
          chk("R5 dispatch method", disp_mthd, q_dm.pop_front());
          chk("R5 dispatch data", disp_data, q_dd.pop_front());
          disp_yield = q_dy.pop_front();
          disp_ack   = 1'b1;
        end
      end
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL R9 watchdog expired act=busy exp=idle");
    finish_run();
  end

  task automatic wait_idle(input int target);
    while (idle_cnt < target) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;

    // buffer A at word 64: writes, drop, count0, dispatch with yields, write
    mem[64] = hw(1, 3, 0, 'h200);
    mem[65] = 32'hA0; mem[66] = 32'hA1; mem[67] = 32'hA2;
    mem[68] = hw(6, 2, 0, 'h23C);
    mem[69] = 32'hB0; mem[70] = 32'hB1;
    mem[71] = hw(1, 0, 0, 'h200);
    mem[72] = hw(1, 2, 5, 'h108);
    mem[73] = 32'hC0; mem[74] = 32'hC1;
    mem[75] = hw(6, 1, 0, 'h204);
    mem[76] = 32'hD0;
    put_entry(0, 64, 13);
    put_entry(1, 100, 0);
    mem[128] = hw(1, 1, 0, 'h208);
    mem[129] = 32'hE0;
    put_entry(2, 128, 2);

    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 get_idx", get_idx, 0);
    chk("R1 busy", busy, 0);
    chk("R1 err", err, 0);
    chk("R1 strobes", {st_we, disp_req, yield_evt, idle_pulse}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle after release", {busy, get_idx}, 0);

    // R2 R3 R4: three writes, idx15 write, 0x240 dropped, count 0 header
    exp_w(0, 32'hA0); exp_w(1, 32'hA1); exp_w(2, 32'hA2);
    exp_w(15, 32'hB0);
    // R5 R6 R7: second word yields twice; replay includes first word
    exp_d('h108, 32'hC0, 0); exp_d('h10C, 32'hC1, 1);
    exp_d('h108, 32'hC0, 0); exp_d('h10C, 32'hC1, 1);
    exp_d('h108, 32'hC0, 0); exp_d('h10C, 32'hC1, 0);
    q_yp.push_back(1); q_yg.push_back(0);
    q_yp.push_back(0); q_yg.push_back(0);
    exp_w(1, 32'hD0);
    // R8 zero-length slot 1, then slot 2
    exp_w(2, 32'hE0);
    put_idx = 2'd3;
    @(negedge clk);
    chk("R9 busy raised", busy, 1);
    wait_idle(1);
    chk("R8 get after three slots", get_idx, 3);
    chk("R9 busy low", busy, 0);
    chk("R9 one idle pulse", idle_cnt, 1);
    chk("R4 R5 queues drained", q_widx.size() + q_dm.size() + q_yp.size(), 0);

    // slot 3 yields on its first command; slot 0 reused (wrap)
    mem[160] = hw(1, 1, 2, 'h100);
    mem[161] = 32'hF0;
    mem[162] = hw(1, 1, 0, 'h20C);
    mem[163] = 32'hF1;
    put_entry(3, 160, 4);
    mem[192] = hw(6, 1, 0, 'h238);
    mem[193] = 32'h99;
    put_entry(0, 192, 2);
    exp_d('h100, 32'hF0, 1);
    q_yp.push_back(0); q_yg.push_back(3);
    exp_d('h100, 32'hF0, 0);
    exp_w(3, 32'hF1);
    exp_w(14, 32'h99);
    put_idx = 2'd1;
    wait_idle(2);
    chk("R8 get wrapped", get_idx, 1);
    chk("R9 second idle pulse", idle_cnt, 2);
    chk("R7 queues drained", q_widx.size() + q_dm.size() + q_yp.size(), 0);

    // R10 unsupported kind 3 in slot 1
    mem[224] = hw(3, 1, 0, 'h200);
    mem[225] = 32'h55;
    mem[226] = hw(1, 1, 0, 'h200);
    mem[227] = 32'h66;
    put_entry(1, 224, 4);
    put_idx = 2'd2;
    repeat (20) @(negedge clk);
    chk("R10 err set", err, 1);
    chk("R10 busy low", busy, 0);
    chk("R10 get frozen", get_idx, 1);
    put_idx = 2'd3;
    repeat (20) @(negedge clk);
    chk("R10 err sticky", err, 1);
    chk("R10 get still frozen", get_idx, 1);
    chk("R10 no idle pulse", idle_cnt, 2);
    chk("R10 no reads", mem_req, 0);

    finish_run();
  end

endmodule